// File: doc/BRIEF.md
# Parallelism-Aware Batch Request Scheduler

This block holds the pending requests of one DRAM bank and names the request that should be issued next. Each request carries a thread identifier and a row address. The block stores its own arrival order for each request. A single-entry lane accepts new requests. The controller supplies the row that the bank currently has open, and it takes the offered request by pulsing `issue`.

Requests are served in batches. When the buffer holds no marked request, the scheduler marks, for each thread, that thread's oldest requests up to a fixed cap. At the same moment it ranks every thread by how many requests the thread placed in the batch: the lightest thread gets the best rank, and the lower thread number wins a tie. Requests that arrive while a batch is in progress stay unmarked until the next batch forms. Inside the batch the order is: open-row hits first, then better thread rank, then older requests.

A controller with several banks uses one instance for each bank.

Top module: `pabs_sched`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `sel_valid` and `full` are 0.
- R2: A request offered with `enq_valid` when `full` is low goes into the lowest-numbered free slot, and that slot number is the index later shown on `sel_idx`. `full` is 1 exactly when all DEPTH slots hold a request. A request offered while `full` is 1 is dropped.
- R3: When the buffer is non-empty and holds no marked request, a batch forms on that clock edge. For each thread, the up-to-CAP oldest requests present are marked. `sel_valid` is 0 in the following cycle.
- R4: `sel_valid` only ever names a marked request. A request that arrived after the batch formed is never offered while any marked request remains.
- R5: Among marked requests, a request whose row equals `open_row` while `open_row_valid` is 1 is offered before any marked request that does not hit.
- R6: Among marked requests with equal hit status, the request of the better-ranked thread is offered first. A thread with fewer marked requests at formation ranks better, and the lower thread ID wins a tie. Ranks hold until the next formation.
- R7: Among marked requests with equal hit status and equal rank, the older request is offered first.
- R8: `sel_valid`/`sel_idx` are registered. They reflect the buffer state and the open-row inputs of the previous cycle. In the cycle after an accepted issue, `sel_valid` is 0.
- R9: `issue` while `sel_valid` is 1 removes the offered request. `issue` while `sel_valid` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Offer a new request this cycle |
| enq_thread | input | TID_W | Thread ID of the new request |
| enq_row | input | ROW_W | Row address of the new request |
| full | output | 1 | All slots occupied |
| open_row_valid | input | 1 | The bank has a row open |
| open_row | input | ROW_W | Currently open row |
| sel_valid | output | 1 | `sel_idx` names a request ready to issue |
| sel_idx | output | IDX_W | Slot of the offered request |
| issue | input | 1 | Take the offered request |

## Verification
A wrong internal state shows up at `sel_idx` within two cycles. A mark bit that was set wrongly or never cleared lets a late arrival jump ahead, or makes the batch never end, which stalls `sel_valid` low. A stale or inverted rank swaps the order of two threads in the batch at their first contested pick. A corrupted age relation reverses two requests of one thread. The bench checks `sel_valid`, `sel_idx` and `full` on every cycle against a behavioural model. It also replays fixed request mixes whose issue order is worked out from the requirements.

// File: rtl/pabs_pkg.sv
package pabs_pkg;
  localparam int DEF_DEPTH   = 16;
  localparam int DEF_THREADS = 4;
  localparam int DEF_CAP     = 5;
  localparam int DEF_ROW_W   = 10;

  // Clamp a per-thread request count to the batch cap.
  function automatic int clamp_cap(input int n, input int cap);
    return (n > cap) ? cap : n;
  endfunction
endpackage

// File: rtl/pabs_age_matrix.sv
// Pairwise age relation: older_o[i][j] set means slot i arrived before slot j.
module pabs_age_matrix #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_idx,
  output logic [DEPTH-1:0] older_o [DEPTH]
);
  logic [DEPTH-1:0] older_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
    end else if (alloc_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (IDX_W'(i) == alloc_idx) older_q[i] <= '0;
        else older_q[i][alloc_idx] <= 1'b1;
      end
    end
  end

  assign older_o = older_q;
endmodule

// File: rtl/pabs_batch_former.sv
// Computes the mark set and the thread ranks that a new batch would receive.
module pabs_batch_former
  import pabs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NTHR  = 4,
  parameter int CAP   = 5,
  localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic [DEPTH-1:0] valid_i,
  input  logic [TID_W-1:0] thr_i   [DEPTH],
  input  logic [DEPTH-1:0] older_i [DEPTH],
  output logic [DEPTH-1:0] mark_o,
  output logic [TID_W-1:0] rank_o  [NTHR]
);
  int tcnt [NTHR];

  // A slot is marked when fewer than CAP older slots of its thread are present.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int ahead;
      ahead = 0;
      for (int j = 0; j < DEPTH; j++) begin
        if (j != i && valid_i[j] && thr_i[j] == thr_i[i] && older_i[j][i])
          ahead++;
      end
      mark_o[i] = valid_i[i] && (ahead < CAP);
    end
  end

  // Intensity per thread, then rank: lighter first, lower ID on a tie.
  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      int n;
      n = 0;
      for (int i = 0; i < DEPTH; i++)
        if (valid_i[i] && int'(thr_i[i]) == t) n++;
      tcnt[t] = clamp_cap(n, CAP);
    end
    for (int t = 0; t < NTHR; t++) begin
      int r;
      r = 0;
      for (int u = 0; u < NTHR; u++)
        if (tcnt[u] < tcnt[t] || (tcnt[u] == tcnt[t] && u < t)) r++;
      rank_o[t] = TID_W'(r);
    end
  end
endmodule

// File: rtl/pabs_picker.sv
// Tournament over candidate slots: hit, then rank, then age.
module pabs_picker #(
  parameter int DEPTH = 16,
  parameter int TID_W = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] cand_i,
  input  logic [DEPTH-1:0] hit_i,
  input  logic [TID_W-1:0] rank_i  [DEPTH],
  input  logic [DEPTH-1:0] older_i [DEPTH],
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [DEPTH-1:0] beat [DEPTH];
  logic [DEPTH-1:0] win;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_row
    for (genvar gj = 0; gj < DEPTH; gj++) begin : g_col
      if (gi == gj) begin : g_self
        assign beat[gi][gj] = 1'b1;
      end else begin : g_pair
        assign beat[gi][gj] = !cand_i[gj]
          || (hit_i[gi] && !hit_i[gj])
          || (hit_i[gi] == hit_i[gj] && rank_i[gi] < rank_i[gj])
          || (hit_i[gi] == hit_i[gj] && rank_i[gi] == rank_i[gj] && older_i[gi][gj]);
      end
    end
    assign win[gi] = cand_i[gi] && (&beat[gi]);
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (win[i]) idx_o = idx_o | IDX_W'(i);
  end
  assign found_o = |win;
endmodule

// File: rtl/pabs_sched.sv
module pabs_sched
  import pabs_pkg::*;
#(
  parameter int DEPTH = DEF_DEPTH,
  parameter int NTHR  = DEF_THREADS,
  parameter int CAP   = DEF_CAP,
  parameter int ROW_W = DEF_ROW_W,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enq_valid,
  input  logic [TID_W-1:0] enq_thread,
  input  logic [ROW_W-1:0] enq_row,
  output logic             full,
  input  logic             open_row_valid,
  input  logic [ROW_W-1:0] open_row,
  output logic             sel_valid,
  output logic [IDX_W-1:0] sel_idx,
  input  logic             issue
);
  logic [DEPTH-1:0] valid_q, mark_q, valid_d, mark_d;
  logic [TID_W-1:0] thr_q    [DEPTH];
  logic [ROW_W-1:0] row_q    [DEPTH];
  logic [TID_W-1:0] rank_q   [NTHR];
  logic [TID_W-1:0] new_rank [NTHR];
  logic [TID_W-1:0] ent_rank [DEPTH];
  logic [DEPTH-1:0] older    [DEPTH];
  logic [DEPTH-1:0] new_mark, hit, cand;
  logic [IDX_W-1:0] free_idx, pick_idx, sel_idx_q;
  logic             sel_valid_q, found, forming, do_enq, do_issue;

  assign full     = &valid_q;
  assign do_enq   = enq_valid && !full;
  assign do_issue = issue && sel_valid_q;
  assign forming  = (|valid_q) && ((valid_q & mark_q) == '0);
  assign cand     = valid_q & mark_q;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!valid_q[i]) free_idx = IDX_W'(i);
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hit[i]      = open_row_valid && (row_q[i] == open_row);
      ent_rank[i] = rank_q[thr_q[i]];
    end
  end

  pabs_age_matrix #(.DEPTH(DEPTH)) u_age (
    .clk(clk), .rst(rst), .alloc_en(do_enq), .alloc_idx(free_idx), .older_o(older)
  );

  pabs_batch_former #(.DEPTH(DEPTH), .NTHR(NTHR), .CAP(CAP)) u_form (
    .valid_i(valid_q), .thr_i(thr_q), .older_i(older), .mark_o(new_mark), .rank_o(new_rank)
  );

  pabs_picker #(.DEPTH(DEPTH), .TID_W(TID_W)) u_pick (
    .cand_i(cand), .hit_i(hit), .rank_i(ent_rank), .older_i(older),
    .found_o(found), .idx_o(pick_idx)
  );

  always_comb begin
    valid_d = valid_q;
    mark_d  = mark_q;
    if (do_issue) begin
      valid_d[sel_idx_q] = 1'b0;
      mark_d[sel_idx_q]  = 1'b0;
    end
    if (forming) mark_d = new_mark;
    if (do_enq) begin
      valid_d[free_idx] = 1'b1;
      mark_d[free_idx]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q     <= '0;
      mark_q      <= '0;
      sel_valid_q <= 1'b0;
      sel_idx_q   <= '0;
      for (int t = 0; t < NTHR; t++) rank_q[t] <= '0;
    end else begin
      valid_q     <= valid_d;
      mark_q      <= mark_d;
      sel_valid_q <= found && !forming && !do_issue;
      sel_idx_q   <= pick_idx;
      if (forming) rank_q <= new_rank;
    end
  end

  always_ff @(posedge clk) begin
    if (do_enq) begin
      thr_q[free_idx] <= enq_thread;
      row_q[free_idx] <= enq_row;
    end
  end

  assign sel_valid = sel_valid_q;
  assign sel_idx   = sel_idx_q;
endmodule

// File: rtl/pabs_sched_chk.sv
module pabs_sched_chk #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             issue,
  input logic             sel_valid,
  input logic [IDX_W-1:0] sel_idx,
  input logic             full,
  input logic [DEPTH-1:0] valid_q,
  input logic [DEPTH-1:0] mark_q
);
  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    full && !(issue && sel_valid) |=> full);

  // R3
  batch_form_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q != '0) && ((valid_q & mark_q) == '0) |=> ((valid_q & mark_q) != '0) && !sel_valid);

  // R4
  sel_marked_chk: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> valid_q[sel_idx] && mark_q[sel_idx]);

  // R8
  issue_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    issue && sel_valid |=> !sel_valid);

  // R9
  issue_remove_chk: assert property (@(posedge clk) disable iff (rst)
    issue && sel_valid |=> !valid_q[$past(sel_idx)]);
endmodule

bind pabs_sched pabs_sched_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .issue(issue), .sel_valid(sel_valid), .sel_idx(sel_idx),
  .full(full), .valid_q(valid_q), .mark_q(mark_q)
);

// File: tb/pabs_sched_tb.sv
`timescale 1ns/1ps
module pabs_sched_tb;
  localparam int D = 16, T = 4, C = 5, RW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enq_valid = 1'b0;
  logic [1:0] enq_thread = '0;
  logic [RW-1:0] enq_row = '0;
  logic full;
  logic open_row_valid = 1'b0;
  logic [RW-1:0] open_row = '0;
  logic sel_valid;
  logic [3:0] sel_idx;
  logic issue = 1'b0;

  always #2 clk = ~clk;

  pabs_sched #(.DEPTH(D), .NTHR(T), .CAP(C), .ROW_W(RW)) u_dut (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_thread(enq_thread),
    .enq_row(enq_row), .full(full), .open_row_valid(open_row_valid),
    .open_row(open_row), .sel_valid(sel_valid), .sel_idx(sel_idx), .issue(issue)
  );

  int errors = 0, checks = 0;
  bit chk_en = 0, done = 0;
  string tag = "R8";

  // Behavioural reference model
  bit m_valid [D];
  bit m_mark  [D];
  int m_thr   [D];
  int m_row   [D];
  int m_seq   [D];
  int m_rank  [T];
  bit m_sv;
  int m_idx;
  int seqc;

  function automatic bit better(int a, int b);
    bit ha, hb;
    ha = open_row_valid && (m_row[a] == int'(open_row));
    hb = open_row_valid && (m_row[b] == int'(open_row));
    if (ha != hb) return ha;
    if (m_rank[m_thr[a]] != m_rank[m_thr[b]]) return m_rank[m_thr[a]] < m_rank[m_thr[b]];
    return m_seq[a] < m_seq[b];
  endfunction

  always @(posedge clk) begin : mdl
    bit any_v, any_m, forming, pop, allv;
    int best, slot;
    int cnt [T];
    if (rst) begin
      for (int i = 0; i < D; i++) begin m_valid[i] = 0; m_mark[i] = 0; end
      for (int t = 0; t < T; t++) m_rank[t] = 0;
      m_sv = 0; m_idx = 0; seqc = 0;
    end else begin
      any_v = 0; any_m = 0; allv = 1; best = -1; slot = -1;
      for (int i = 0; i < D; i++) begin
        any_v |= m_valid[i];
        any_m |= m_valid[i] && m_mark[i];
        allv &= m_valid[i];
        if (!m_valid[i] && slot < 0) slot = i;
        if (m_valid[i] && m_mark[i] && (best < 0 || better(i, best))) best = i;
      end
      forming = any_v && !any_m;
      pop = issue && m_sv;
      if (pop) begin m_valid[m_idx] = 0; m_mark[m_idx] = 0; end
      if (forming) begin
        for (int t = 0; t < T; t++) cnt[t] = 0;
        for (int i = 0; i < D; i++) begin
          int older_same;
          older_same = 0;
          for (int j = 0; j < D; j++)
            if (m_valid[j] && m_thr[j] == m_thr[i] && m_seq[j] < m_seq[i]) older_same++;
          m_mark[i] = m_valid[i] && older_same < C;
          if (m_valid[i]) cnt[m_thr[i]]++;
        end
        for (int t = 0; t < T; t++) if (cnt[t] > C) cnt[t] = C;
        for (int t = 0; t < T; t++) begin
          m_rank[t] = 0;
          for (int u = 0; u < T; u++)
            if (cnt[u] < cnt[t] || (cnt[u] == cnt[t] && u < t)) m_rank[t]++;
        end
      end
      if (enq_valid && !allv) begin
        m_valid[slot] = 1; m_mark[slot] = 0;
        m_thr[slot] = int'(enq_thread); m_row[slot] = int'(enq_row);
        m_seq[slot] = seqc; seqc++;
      end
      m_sv = !forming && !pop && best >= 0;
      if (m_sv) m_idx = best;
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    bit ef;
    if (chk_en && !rst && !done) begin
      ef = 1;
      for (int i = 0; i < D; i++) ef &= m_valid[i];
      checks++;
      if (sel_valid !== m_sv || full !== ef || (m_sv && int'(sel_idx) != m_idx)) begin
        errors++;
        $display("FAIL %s R8 cycle compare: actual sv=%0b idx=%0d full=%0b expected sv=%0b idx=%0d full=%0b",
                 tag, sel_valid, sel_idx, full, m_sv, m_idx, ef);
      end
    end
  end

  task automatic enq(input int th, input int rw);
    enq_valid = 1; enq_thread = 2'(th); enq_row = RW'(rw);
    @(negedge clk);
    enq_valid = 0;
  endtask

  task automatic take(input int exp_idx, input string rq);
    while (!sel_valid) @(negedge clk);
    checks++;
    if (exp_idx >= 0 && int'(sel_idx) != exp_idx) begin
      errors++;
      $display("FAIL %s issue order: actual=%0d expected=%0d", rq, sel_idx, exp_idx);
    end
    issue = 1;
    @(negedge clk);
    issue = 0;
  endtask

  task automatic expect_bit(input bit act, input bit exp, input string rq);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", rq, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; chk_en = 1;
    // R1: reset state
    expect_bit(sel_valid, 1'b0, "R1 sel_valid after reset");
    expect_bit(full, 1'b0, "R1 full after reset");

    // R6 and R7: rank by intensity, then age
    tag = "R6";
    enq(3, 3);
    enq(0, 10); enq(0, 11); enq(0, 12); enq(1, 13); enq(2, 14); enq(2, 15);
    take(0, "R3 lone first batch");
    take(4, "R6 lightest thread first");
    take(5, "R6 next thread");
    take(6, "R7 older within thread");
    take(1, "R6 heaviest thread last");
    take(2, "R7 age order");
    take(3, "R7 age order");

    // R5: open-row hit beats rank
    tag = "R5";
    open_row_valid = 1; open_row = RW'(7);
    enq(3, 3);
    enq(0, 1); enq(0, 7); enq(1, 9);
    take(0, "R5 lone batch");
    take(2, "R5 hit first");
    take(3, "R6 rank after hit");
    take(1, "R6 heavier thread last");

    // R3 and R4: per-thread cap, late or uncapped requests wait
    tag = "R3";
    open_row = RW'(9);
    enq(3, 3);
    for (int k = 0; k < 5; k++) enq(0, 20 + k);
    enq(0, 9); enq(0, 9); enq(1, 4);
    take(0, "R3 lone batch");
    take(8, "R6 light thread first");
    take(1, "R4 marked non-hit before unmarked hit");
    take(2, "R4 marked first");
    take(3, "R4 marked first");
    take(4, "R4 marked first");
    take(5, "R3 cap of five reached");
    take(6, "R3 capped requests in next batch");
    take(7, "R3 capped requests in next batch");

    // R2: fill, overflow dropped, drain
    tag = "R2";
    open_row_valid = 0;
    for (int k = 0; k < D; k++) enq(k % T, k);
    expect_bit(full, 1'b1, "R2 full after DEPTH requests");
    enq(0, 99);
    expect_bit(full, 1'b1, "R2 still full after dropped request");
    for (int k = 0; k < D; k++) take(-1, "R2 drain");
    repeat (6) @(negedge clk);
    expect_bit(sel_valid, 1'b0, "R2 dropped request never offered");
    expect_bit(full, 1'b0, "R2 empty after drain");

    // R8 and R9: random traffic, stray issue pulses included
    tag = "R9";
    for (int c = 0; c < 4000; c++) begin
      enq_valid = ($urandom_range(0, 1) == 1);
      enq_thread = 2'($urandom_range(0, T - 1));
      enq_row = RW'($urandom_range(0, 7));
      if ($urandom_range(0, 7) == 0) begin
        open_row_valid = ($urandom_range(0, 3) != 0);
        open_row = RW'($urandom_range(0, 7));
      end
      issue = ($urandom_range(0, 1) == 1);
      @(negedge clk);
    end
    enq_valid = 0; issue = 0;
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule